// File: doc/BRIEF.md
# Infrared Port FIFO Pair with Depth-Dependent Threshold Flags

This unit holds the two byte queues of an infrared serial port: one for received bytes and one for bytes waiting to be sent. Both queues share a single depth setting, which chooses either 16 or 32 byte slots. The serial side pushes received bytes and pops bytes to transmit. The host side pops received bytes and pushes outgoing ones.

Each direction has a two-bit level selector. The trigger level that a selector code stands for depends on the direction and on the active depth. The receive flag is high while enough bytes are waiting. The transmit flag is high while the transmit queue has drained below its level. Both flags are pure functions of the present occupancy and the selected level, so they need no acknowledge. Changing the depth setting empties both queues.

Top module: `ir_fifo_thresh_unit`

## Requirements
- R1: After reset both occupancies read 0, both overrun bits read 0, the receive flag reads 0, the transmit flag reads 1 and the active depth is 16.
- R2: Each queue returns bytes in the order they were pushed. While a queue is non-empty, its pop-data output shows the oldest byte, and a pop removes that byte at the clock edge.
- R3: A queue holds at most 16 bytes when the active depth is 16 (`deep_sel` = 0) and at most 32 when it is 32 (`deep_sel` = 1). A push to a full queue is dropped, leaves the occupancy unchanged and sets that queue's overrun bit, which stays set until reset.
- R4: A pop from an empty queue leaves the occupancy unchanged, and pop-data reads 0 while the queue is empty.
- R5: A push and a pop in the same cycle are evaluated against the occupancy before the edge. On an empty queue only the push takes effect. On a full queue only the pop takes effect, and the push is counted as an overrun. Otherwise both take effect and the occupancy is unchanged.
- R6: With depth 16, receive selector codes 0, 1, 2, 3 give levels 1, 4, 8, 14, and the receive flag is high exactly when receive occupancy is at least the level.
- R7: With depth 32, receive selector codes 0, 1, 2, 3 give levels 1, 4, 16, 26 under the same rule.
- R8: With depth 16, transmit selector codes 0, 1, 2, 3 give levels 1, 3, 9, 13, and the transmit flag is high exactly when transmit occupancy is strictly below the level.
- R9: With depth 32, transmit selector codes 0, 1, 2, 3 give levels 1, 7, 17, 25 under the same rule.
- R10: When `deep_sel` differs from the active depth at a clock edge, that edge adopts the new depth and empties both queues. Pushes and pops in that cycle are ignored, and the overrun bits keep their values.
- R11: Both flags follow a change of a level selector within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sel | input | 1 | Requested depth: 0 selects 16 bytes, 1 selects 32 bytes |
| rx_lvl_sel | input | 2 | Receive level selector code |
| tx_lvl_sel | input | 2 | Transmit level selector code |
| rx_push | input | 1 | Write one received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_pop_data | output | 8 | Oldest received byte, 0 when empty |
| rx_count | output | 6 | Receive occupancy |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_push | input | 1 | Write one byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Remove the oldest byte to send |
| tx_pop_data | output | 8 | Oldest byte to send, 0 when empty |
| tx_count | output | 6 | Transmit occupancy |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_thresh_irq | output | 1 | Receive level reached |
| tx_thresh_irq | output | 1 | Transmit occupancy below level |

## Verification
The receive queue is filled one byte at a time past its capacity while the selector is cycled. This shows whether the flag turns on at exactly the tabulated level for each code and depth, and whether a one-off level error or a swapped table exists. The transmit queue is filled and then drained, so its flag is seen in both directions, which separates the strict "below" test from "at or below". Simultaneous push and pop at empty, mid and full occupancy separate the pre-edge evaluation rule from its variants. Depth toggles with data present show the flush and the retained overrun bits. A long random phase with occasional depth toggles compares every output against a queue-based model on each cycle.

// File: rtl/ir_fifo_pkg.sv
package ir_fifo_pkg;
    localparam int BYTE_W      = 8;
    localparam int DEPTH_SMALL = 16;
    localparam int DEPTH_LARGE = 32;
    localparam int PTR_W       = $clog2(DEPTH_LARGE);
    localparam int CNT_W       = $clog2(DEPTH_LARGE + 1);
    localparam int SEL_W       = 2;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             overrun;
    } fifo_state_t;

    typedef struct packed {
        logic deep;
    } ctrl_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import ir_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);
    fifo_state_t st_d, st_q;
    logic [BYTE_W-1:0] mem_q [DEPTH_LARGE];
    logic              we;
    logic              has_room;
    logic              has_data;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] lim);
        if ({1'b0, p} == lim - CNT_W'(1)) return '0;
        return p + PTR_W'(1);
    endfunction

    assign has_room = st_q.count < cap;
    assign has_data = st_q.count != '0;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (push && has_room) begin
                we          = 1'b1;
                st_d.wr_ptr = advance(st_q.wr_ptr, cap);
            end
            if (push && !has_room) begin
                st_d.overrun = 1'b1;
            end
            if (pop && has_data) begin
                st_d.rd_ptr = advance(st_q.rd_ptr, cap);
            end
            st_d.count = st_q.count
                       + CNT_W'(push && has_room)
                       - CNT_W'(pop && has_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[st_q.wr_ptr] <= push_data;
    end

    assign pop_data = has_data ? mem_q[st_q.rd_ptr] : '0;
    assign count    = st_q.count;
    assign overrun  = st_q.overrun;

    // R3
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH_LARGE));
    // R3
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.overrun |=> st_q.overrun);
    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0 && pop && !push && !flush) |=> (st_q.count == '0));
    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0));
endmodule

// File: rtl/level_map.sv
module level_map
    import ir_fifo_pkg::*;
#(
    parameter bit IS_TX = 1'b0
) (
    input  logic             deep,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] level
);
    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                unique case ({deep, sel})
                    3'b000:  level = CNT_W'(1);
                    3'b001:  level = CNT_W'(3);
                    3'b010:  level = CNT_W'(9);
                    3'b011:  level = CNT_W'(13);
                    3'b100:  level = CNT_W'(1);
                    3'b101:  level = CNT_W'(7);
                    3'b110:  level = CNT_W'(17);
                    default: level = CNT_W'(25);
                endcase
            end
        end else begin : g_rx
            always_comb begin
                unique case ({deep, sel})
                    3'b000:  level = CNT_W'(1);
                    3'b001:  level = CNT_W'(4);
                    3'b010:  level = CNT_W'(8);
                    3'b011:  level = CNT_W'(14);
                    3'b100:  level = CNT_W'(1);
                    3'b101:  level = CNT_W'(4);
                    3'b110:  level = CNT_W'(16);
                    default: level = CNT_W'(26);
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/ir_fifo_thresh_unit.sv
module ir_fifo_thresh_unit
    import ir_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_sel,
    input  logic [SEL_W-1:0]  rx_lvl_sel,
    input  logic [SEL_W-1:0]  tx_lvl_sel,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_pop_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_overrun,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_pop_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_overrun,
    output logic              rx_thresh_irq,
    output logic              tx_thresh_irq
);
    ctrl_state_t ctl_d, ctl_q;
    logic             flush;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] rx_level;
    logic [CNT_W-1:0] tx_level;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.deep = deep_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flush = deep_sel != ctl_q.deep;
    assign cap   = ctl_q.deep ? CNT_W'(DEPTH_LARGE) : CNT_W'(DEPTH_SMALL);

    byte_fifo u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .cap       (cap),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .overrun   (rx_overrun)
    );

    byte_fifo u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .cap       (cap),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .overrun   (tx_overrun)
    );

    level_map #(.IS_TX(1'b0)) u_rx_level (
        .deep  (ctl_q.deep),
        .sel   (rx_lvl_sel),
        .level (rx_level)
    );

    level_map #(.IS_TX(1'b1)) u_tx_level (
        .deep  (ctl_q.deep),
        .sel   (tx_lvl_sel),
        .level (tx_level)
    );

    assign rx_thresh_irq = rx_count >= rx_level;
    assign tx_thresh_irq = tx_count <  tx_level;

    // R6
    rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_thresh_irq);
    // R8
    tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_thresh_irq);
    // R3
    rx_small_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.deep) |-> (rx_count <= CNT_W'(DEPTH_SMALL)));
    // R3
    tx_small_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.deep) |-> (tx_count <= CNT_W'(DEPTH_SMALL)));
endmodule

// File: tb/sim_ir_fifo_thresh_unit.sv
module sim_ir_fifo_thresh_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_sel = 1'b0;
    logic [1:0] rx_lvl_sel = 2'd0;
    logic [1:0] tx_lvl_sel = 2'd0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = 8'd0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_pop_data;
    logic [5:0] rx_count;
    logic       rx_overrun;
    logic       tx_push = 1'b0;
    logic [7:0] tx_push_data = 8'd0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_pop_data;
    logic [5:0] tx_count;
    logic       tx_overrun;
    logic       rx_thresh_irq;
    logic       tx_thresh_irq;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_deep = 1'b0;
    bit m_rx_ovr = 1'b0;
    bit m_tx_ovr = 1'b0;

    always #2 clk = ~clk;

    ir_fifo_thresh_unit u0 (
        .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel),
        .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_overrun(rx_overrun),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_overrun(tx_overrun),
        .rx_thresh_irq(rx_thresh_irq), .tx_thresh_irq(tx_thresh_irq)
    );

    function automatic int rx_lvl(bit deep, int code);
        int small_t[4] = '{1, 4, 8, 14};
        int large_t[4] = '{1, 4, 16, 26};
        return deep ? large_t[code] : small_t[code];
    endfunction

    function automatic int tx_lvl(bit deep, int code);
        int small_t[4] = '{1, 3, 9, 13};
        int large_t[4] = '{1, 7, 17, 25};
        return deep ? large_t[code] : small_t[code];
    endfunction

    task automatic check(string tag, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, actual, expected, $time);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_deep = 1'b0; m_rx_ovr = 1'b0; m_tx_ovr = 1'b0;
        end else if (deep_sel != m_deep) begin
            rxq.delete(); txq.delete();
            m_deep = deep_sel;
        end else begin
            int cap;
            int rs;
            int ts;
            cap = m_deep ? 32 : 16;
            rs = rxq.size();
            ts = txq.size();
            if (rx_pop && rs > 0) void'(rxq.pop_front());
            if (rx_push) begin
                if (rs < cap) rxq.push_back(rx_push_data);
                else m_rx_ovr = 1'b1;
            end
            if (tx_pop && ts > 0) void'(txq.pop_front());
            if (tx_push) begin
                if (ts < cap) txq.push_back(tx_push_data);
                else m_tx_ovr = 1'b1;
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (cmp_en) begin
            string rtag;
            string ttag;
            rtag = m_deep ? "R7" : "R6";
            ttag = m_deep ? "R9" : "R8";
            check("R3", "rx_count", int'(rx_count), rxq.size());
            check("R3", "tx_count", int'(tx_count), txq.size());
            check("R2", "rx_pop_data", int'(rx_pop_data), rxq.size() > 0 ? int'(rxq[0]) : 0);
            check("R2", "tx_pop_data", int'(tx_pop_data), txq.size() > 0 ? int'(txq[0]) : 0);
            check("R3", "rx_overrun", int'(rx_overrun), int'(m_rx_ovr));
            check("R3", "tx_overrun", int'(tx_overrun), int'(m_tx_ovr));
            check(rtag, "rx_thresh_irq", int'(rx_thresh_irq),
                  int'(rxq.size() >= rx_lvl(m_deep, int'(rx_lvl_sel))));
            check(ttag, "tx_thresh_irq", int'(tx_thresh_irq),
                  int'(txq.size() < tx_lvl(m_deep, int'(tx_lvl_sel))));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state while held
        check("R1", "rx_count", int'(rx_count), 0);
        check("R1", "tx_count", int'(tx_count), 0);
        check("R1", "rx_thresh_irq", int'(rx_thresh_irq), 0);
        check("R1", "tx_thresh_irq", int'(tx_thresh_irq), 1);
        check("R1", "overrun", int'(rx_overrun | tx_overrun), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        step();

        // R4: pop empty
        rx_pop = 1'b1; step(); idle();
        check("R4", "rx_count after empty pop", int'(rx_count), 0);
        check("R4", "rx_pop_data empty", int'(rx_pop_data), 0);

        // R5: push+pop on empty
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'hA5; step(); idle();
        check("R5", "rx_count push+pop empty", int'(rx_count), 1);
        check("R2", "rx head", int'(rx_pop_data), 8'hA5);

        // R3/R6: overfill receive at depth 16 while cycling selector
        for (int i = 0; i < 20; i++) begin
            rx_push = 1'b1; rx_push_data = 8'(i + 1); rx_lvl_sel = 2'(i);
            step();
        end
        idle();
        check("R3", "rx_count full 16", int'(rx_count), 16);
        check("R3", "rx_overrun set", int'(rx_overrun), 1);

        // R5: push+pop on full: only pop
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'h77; step(); idle();
        check("R5", "rx_count push+pop full", int'(rx_count), 15);

        // R11: selector change without clock edge
        rx_pop = 1'b1; repeat (10) step(); idle();
        check("R2", "rx_count drained to 5", int'(rx_count), 5);
        rx_lvl_sel = 2'd1; #0.5;
        check("R11", "rx flag level 4", int'(rx_thresh_irq), 1);
        rx_lvl_sel = 2'd2; #0.5;
        check("R11", "rx flag level 8", int'(rx_thresh_irq), 0);

        // R5: mid-occupancy push+pop
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'h3C; step(); idle();
        check("R5", "rx_count push+pop mid", int'(rx_count), 5);

        // R8: fill transmit at depth 16 sweeping selector, then drain
        for (int i = 0; i < 18; i++) begin
            tx_push = 1'b1; tx_push_data = 8'(8'h80 + i); tx_lvl_sel = 2'(i >> 1);
            step();
        end
        idle();
        check("R3", "tx_overrun set", int'(tx_overrun), 1);
        for (int i = 0; i < 16; i++) begin
            tx_pop = 1'b1; tx_lvl_sel = 2'(i); step();
        end
        idle();

        // R10: depth change flushes with data present
        tx_push = 1'b1; tx_push_data = 8'h11; step(); idle();
        deep_sel = 1'b1; rx_push = 1'b1; tx_push = 1'b1; step(); idle();
        check("R10", "rx_count after flush", int'(rx_count), 0);
        check("R10", "tx_count after flush", int'(tx_count), 0);
        check("R10", "rx_overrun kept", int'(rx_overrun), 1);

        // R7/R9: depth 32 sweeps
        for (int i = 0; i < 36; i++) begin
            rx_push = 1'b1; rx_push_data = 8'(i); rx_lvl_sel = 2'(i);
            tx_push = 1'b1; tx_push_data = 8'(i ^ 8'h5A); tx_lvl_sel = 2'(i >> 2);
            step();
        end
        idle();
        check("R3", "rx_count full 32", int'(rx_count), 32);
        for (int i = 0; i < 34; i++) begin
            rx_pop = 1'b1; tx_pop = 1'b1;
            rx_lvl_sel = 2'(i >> 3); tx_lvl_sel = 2'(i);
            step();
        end
        idle();

        // Random traffic with occasional depth toggles
        for (int i = 0; i < 3000; i++) begin
            rx_push = 1'($urandom_range(0, 99) < 55);
            rx_pop  = 1'($urandom_range(0, 99) < 45);
            tx_push = 1'($urandom_range(0, 99) < 45);
            tx_pop  = 1'($urandom_range(0, 99) < 55);
            rx_push_data = 8'($urandom);
            tx_push_data = 8'($urandom);
            rx_lvl_sel = 2'($urandom);
            tx_lvl_sel = 2'($urandom);
            if ($urandom_range(0, 299) == 0) deep_sel = ~deep_sel;
            step();
        end
        idle();
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule